// File: doc/BRIEF.md
# Double-Buffered Transmit Serializer with Interrupts

This block turns bytes written over a small register bus into a serial bit stream. A byte written to the data address lands in a holding register. A transmit request moves it into a shift register, which then sends one bit for every bit-enable strobe. While the shifter is busy, software can already write the next byte. The shifter picks that byte up at the same edge that sends its current last bit, so the stream has no gap between bytes.

Four events are tracked. An underflow is a transmit request while nothing is held. An overflow is a data write that overwrites a byte the shifter has not yet taken. Empty is the hand-off of the held byte into the shifter. Done is the shifter finishing with no byte pending. Each event sets a sticky status flag, which software clears by writing ones. A single interrupt line is raised when any flag is set whose enable bit is also set.

Top module: `sertx_core`

## Requirements
- R1: After reset the enable and status registers read 0, `irq` is low, `tx_busy` is low and `ser_out` is 0.
- R2: The enable register is at address 1. Bits 3:0 are writable. Bits 7:4 ignore writes and always read 0.
- R3: The event bit positions are the same in the enable and status registers: bit 3 underflow, bit 2 overflow, bit 1 done, bit 0 empty. `irq` is high exactly when some status bit is 1 and its enable bit is also 1.
- R4: A `tx_req` while the holding register is empty sets status bit 3 and leaves the shifter idle.
- R5: A `tx_req` while the shifter is idle and a byte is held does three things at that edge: it moves the byte into the shifter, raises `tx_busy`, and sets status bit 0. The holding register is then free.
- R6: Bits leave MSB first. `ser_out` shows the current bit while `tx_busy` is high. Each `bit_stb` advances the stream by exactly one bit.
- R7: When the strobe that sends a byte's last bit arrives and a byte is held, that byte enters the shifter at the same edge. The first bit of the new byte follows the last bit of the old one with no idle slot, and status bit 0 is set again.
- R8: A data write while a byte is held, in a cycle with no hand-off, replaces the held byte and sets status bit 2.
- R9: A data write in the same cycle as a hand-off is kept as the new pending byte and does not set status bit 2.
- R10: When the last bit is strobed and no byte is held, `tx_busy` falls and status bit 1 is set.
- R11: The status register is at address 2. Writing a 1 to a bit clears that bit, and writing 0 leaves it unchanged. If an event occurs in the same cycle as a clear, the flag stays set.
- R12: Address 0 accepts data writes and reads back the last byte written there. Reads from addresses other than 0, 1 and 2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| tx_req | input | 1 | Transmit request pulse |
| bit_stb | input | 1 | Bit-enable strobe, one bit per pulse |
| ser_out | output | 1 | Serial data out |
| tx_busy | output | 1 | Shifter holds a byte in transmission |
| irq | output | 1 | Interrupt, enabled status flags ORed |

## Verification
The assertions assume three things about the inputs. `tx_req` and `bit_stb` are single-cycle pulses sampled at the rising edge. A data write and a hand-off may share a cycle. The shifter's state changes only on a strobe or a start request. The bench drives every input at the falling clock edge and holds it for exactly one cycle. Several stimuli are combined deliberately in one cycle: a write together with the final strobe, and a status clear together with an underflow. This exercises the same-cycle corners without relying on the order of events at an edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int NUM_EV = 4;
   localparam int EV_EMPTY = 0;
   localparam int EV_DONE  = 1;
   localparam int EV_OVF   = 2;
   localparam int EV_UNF   = 3;

   typedef enum logic [1:0] {
      RA_DATA = 2'd0,
      RA_IEN  = 2'd1,
      RA_STAT = 2'd2
   } reg_addr_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_vld,
   output logic              ovf_ev
);
   // a write that lands while a byte waits and nothing takes it loses the old byte
   assign ovf_ev = wr && hold_vld && !take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         hold_vld <= 1'b0;
      end else begin
         if (wr) begin
            hold_q   <= wdata;
            hold_vld <= 1'b1;
         end else if (take) begin
            hold_vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_req,
   input  logic              bit_stb,
   input  logic              hold_vld,
   input  logic [DATA_W-1:0] hold_q,
   output logic              take,
   output logic              done_ev,
   output logic              busy,
   output logic              ser_out
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              last_stb;
   logic              cur_bit;

   assign last_stb = busy && bit_stb && (cnt_q == LAST_IDX);
   assign take     = (tx_req && !busy && hold_vld) || (last_stb && hold_vld);
   assign done_ev  = last_stb && !hold_vld;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit = sh_q[DATA_W-1];
         assign sh_next = {sh_q[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign cur_bit = sh_q[0];
         assign sh_next = {1'b0, sh_q[DATA_W-1:1]};
      end
   endgenerate

   assign ser_out = busy && cur_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
      end else if (take) begin
         sh_q  <= hold_q;
         cnt_q <= '0;
         busy  <= 1'b1;
      end else if (done_ev) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy && bit_stb) begin
         sh_q  <= sh_next;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sertx_regs.sv
module sertx_regs
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NUM_EV-1:0] ev,
   input  logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              data_wr,
   output logic [NUM_EV-1:0] en_q,
   output logic [NUM_EV-1:0] stat_q
);
   logic sel_data, sel_ien, sel_stat;

   assign sel_data = (bus_addr == ADDR_W'(RA_DATA));
   assign sel_ien  = (bus_addr == ADDR_W'(RA_IEN));
   assign sel_stat = (bus_addr == ADDR_W'(RA_STAT));
   assign data_wr  = bus_wr && sel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (bus_wr && sel_ien) begin
         en_q <= bus_wdata[NUM_EV-1:0];
      end
   end

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stat_q[i] <= 1'b0;
            else if (ev[i])
               stat_q[i] <= 1'b1;
            else if (bus_wr && sel_stat && bus_wdata[i])
               stat_q[i] <= 1'b0;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_data)
         bus_rdata = hold_q;
      else if (sel_ien)
         bus_rdata[NUM_EV-1:0] = en_q;
      else if (sel_stat)
         bus_rdata[NUM_EV-1:0] = stat_q;
   end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tx_req,
   input  logic              bit_stb,
   output logic              ser_out,
   output logic              tx_busy,
   output logic              irq
);
   initial begin
      if (DATA_W < NUM_EV || DATA_W < 2)
         $error("sertx_core: DATA_W too small for the flag registers");
      if (ADDR_W < 2)
         $error("sertx_core: ADDR_W must hold three register addresses");
   end

   logic [DATA_W-1:0] hold_q;
   logic              hold_vld;
   logic              data_wr;
   logic              take;
   logic              done_ev;
   logic              ovf_ev;
   logic              unf_ev;
   logic [NUM_EV-1:0] ev;
   logic [NUM_EV-1:0] en_q;
   logic [NUM_EV-1:0] stat_q;

   assign unf_ev       = tx_req && !hold_vld;
   assign ev[EV_EMPTY] = take;
   assign ev[EV_DONE]  = done_ev;
   assign ev[EV_OVF]   = ovf_ev;
   assign ev[EV_UNF]   = unf_ev;
   assign irq          = |(stat_q & en_q);

   sertx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ev(ev), .hold_q(hold_q), .bus_rdata(bus_rdata),
      .data_wr(data_wr), .en_q(en_q), .stat_q(stat_q)
   );

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(bus_wdata), .take(take),
      .hold_q(hold_q), .hold_vld(hold_vld), .ovf_ev(ovf_ev)
   );

   sertx_shift #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .bit_stb(bit_stb),
      .hold_vld(hold_vld), .hold_q(hold_q), .take(take), .done_ev(done_ev),
      .busy(tx_busy), .ser_out(ser_out)
   );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              tx_req,
   input logic              bit_stb,
   input logic              tx_busy,
   input logic              irq,
   input logic              hold_vld,
   input logic [3:0]        en_q,
   input logic [3:0]        stat_q
);
   a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 4'd0) |-> !irq);

   a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !hold_vld) |=> stat_q[3]);

   a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_busy && hold_vld) |=> (tx_busy && stat_q[0]));

   a_r6_busy_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && !tx_req) |=> $stable(tx_busy));

   a_r8_ovf_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[2]) |-> $past(bus_wr && bus_addr == ADDR_W'(0)));

   a_r10_done_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> stat_q[1]);
endmodule

bind sertx_core sertx_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .tx_req(tx_req), .bit_stb(bit_stb), .tx_busy(tx_busy), .irq(irq),
   .hold_vld(hold_vld), .en_q(en_q), .stat_q(stat_q)
);

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       tx_req = 1'b0;
   logic       bit_stb = 1'b0;
   logic       ser_out, tx_busy, irq;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sertx_core u_sertx_core (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req),
      .bit_stb(bit_stb), .ser_out(ser_out), .tx_busy(tx_busy), .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reg_wr(logic [1:0] a, logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic reg_rd(logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic pulse_req();
      tx_req = 1'b1;
      tick();
      tx_req = 1'b0;
   endtask

   // one strobe: check the current bit before the edge, then advance
   task automatic strobe(logic exp_bit, string req);
      bit_stb = 1'b1;
      #0.5;
      chk(req, ser_out, exp_bit);
      tick();
      bit_stb = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] b, string req);
      for (int i = 7; i >= 0; i--) strobe(b[i], req);
   endtask

   task automatic clear_all();
      reg_wr(2'd2, 8'h0F);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      reg_rd(2'd1, d); chk("R1 enable", d, 8'h00);
      reg_rd(2'd2, d); chk("R1 status", d, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 busy", tx_busy, 1'b0);
      chk("R1 ser_out", ser_out, 1'b0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      reg_wr(2'd1, 8'hFA);
      reg_rd(2'd1, d); chk("R2 reserved bits read zero", d, 8'h0A);
      reg_wr(2'd0, 8'h3C);
      reg_rd(2'd0, d); chk("R12 data readback", d, 8'h3C);
      reg_rd(2'd3, d); chk("R12 unused address", d, 8'h00);
      reg_wr(2'd1, 8'h00);
   endtask

   task automatic t_single();
      logic [7:0] d;
      clear_all();
      pulse_req();
      chk("R5 busy after start", tx_busy, 1'b1);
      reg_rd(2'd2, d); chk("R5 empty flag", d, 8'h01);
      send_byte(8'h3C, "R6 msb first");
      chk("R10 busy falls", tx_busy, 1'b0);
      reg_rd(2'd2, d); chk("R10 done flag", d, 8'h03);
   endtask

   task automatic t_underflow();
      logic [7:0] d;
      clear_all();
      reg_wr(2'd1, 8'h08);
      pulse_req();
      chk("R4 no start", tx_busy, 1'b0);
      reg_rd(2'd2, d); chk("R4 underflow flag", d, 8'h08);
      chk("R3 irq enabled", irq, 1'b1);
      reg_wr(2'd1, 8'h07);
      chk("R3 irq masked", irq, 1'b0);
      // clear and a new underflow in the same cycle: set wins
      bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h08; tx_req = 1'b1;
      tick();
      bus_wr = 1'b0; tx_req = 1'b0;
      reg_rd(2'd2, d); chk("R11 set beats clear", d, 8'h08);
      reg_wr(2'd2, 8'h08);
      reg_rd(2'd2, d); chk("R11 clear by one", d, 8'h00);
      reg_wr(2'd1, 8'h00);
   endtask

   task automatic t_back_to_back();
      logic [7:0] d;
      clear_all();
      reg_wr(2'd0, 8'hA5);
      pulse_req();
      reg_wr(2'd0, 8'h5A);
      send_byte(8'hA5, "R7 first byte");
      chk("R7 still busy at boundary", tx_busy, 1'b1);
      reg_rd(2'd2, d); chk("R7 no overflow, empty set", d, 8'h01);
      send_byte(8'h5A, "R7 second byte no gap");
      chk("R10 busy after chain", tx_busy, 1'b0);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      clear_all();
      reg_wr(2'd1, 8'h04);
      reg_wr(2'd0, 8'h11);
      pulse_req();
      reg_wr(2'd0, 8'h22);
      reg_wr(2'd0, 8'h33);
      reg_rd(2'd2, d); chk("R8 overflow flag", d, 8'h05);
      chk("R3 irq on overflow", irq, 1'b1);
      send_byte(8'h11, "R8 first byte");
      send_byte(8'h33, "R8 newest byte wins");
      reg_wr(2'd1, 8'h00);
   endtask

   task automatic t_load_window();
      logic [7:0] d;
      clear_all();
      reg_wr(2'd0, 8'h44);
      pulse_req();
      reg_wr(2'd0, 8'h55);
      for (int i = 7; i >= 1; i--) strobe(8'h44 >> i, "R9 leading bits");
      bit_stb = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h66;
      #0.5;
      chk("R9 last bit", ser_out, 1'b0);
      tick();
      bit_stb = 1'b0; bus_wr = 1'b0;
      reg_rd(2'd2, d); chk("R9 no overflow", d, 8'h01);
      send_byte(8'h55, "R9 handed byte");
      send_byte(8'h66, "R9 window byte kept");
      chk("R10 end", tx_busy, 1'b0);
   endtask

   initial begin
      #(4.0 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_single();
      t_underflow();
      t_back_to_back();
      t_overflow();
      t_load_window();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule